// File: doc/BRIEF.md
# Oversampled serial slave transmitter

This block sends one byte per chip-select window to a microcontroller over a three-wire serial link made of a serial clock input, an active-low chip select input and one data output. The fast internal system clock is the only clock in the design. The serial clock and the chip select are treated as data: each is sampled into a register chain and re-timed before any logic uses it. Edges of the serial clock are found by comparing the current sampled level with the one sampled before. Because the serial clock never reaches a register clock pin, ringing or crosstalk on that wire cannot advance the logic twice.

When chip select falls, a parallel byte is captured and its most significant bit appears on the data output. Each falling edge of the serial clock moves to the next bit, so the master reads each bit on its rising edge. A down-counter tracks the bit position. After the eighth rising edge the block issues a one-cycle completion pulse. An optional glitch filter on the serial clock accepts a new level only after it has held for a set number of consecutive samples. A clock-enable prescaler can lower the sampling rate without adding a second clock. The system clock must run at least four times faster than the serial clock, and more than that when the filter or prescaler is used.

Top module: `ovs_spi_tx`

## Requirements
- R1: The external reset passes through two synchronizing registers and acts synchronously. Once reset has taken effect, `miso` is 1 and `frame_done` is 0.
- R2: While `csn_pin` is high, `miso` stays 1 and `frame_done` stays 0, whatever `sclk_pin` does.
- R3: When `csn_pin` falls, `tx_byte` is captured and its bit DATA_W-1 (the MSB) drives `miso` before the first rising edge of `sclk_pin`.
- R4: Each falling edge of `sclk_pin` inside a frame moves to the next lower bit. The master therefore reads bit DATA_W-1-i at rising edge i, where edges are counted from 0. The internal bit counter starts at DATA_W-1 and only steps down by one or returns to that start value.
- R5: Changes on `tx_byte` after the capture have no effect on the frame in progress.
- R6: The DATA_W-th rising edge of a frame produces exactly one `frame_done` pulse, one system clock wide. After the DATA_W-th falling edge, `miso` is 1.
- R7: If `csn_pin` rises before the frame completes, no `frame_done` pulse is produced. The next frame starts again from the MSB of the newly captured byte.
- R8: A pulse on `sclk_pin` that lasts fewer than FILT_LEN consecutive samples is ignored. It shifts no bit and produces no completion pulse.
- R9: With PRESCALE greater than 1, `sclk_pin` is sampled only once every PRESCALE system clocks. The serial behaviour of R3 to R8 is unchanged as long as each half period of the serial clock is long enough.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, the only clock in the block |
| rst_ext | input | 1 | External reset, active high, asynchronous to clk |
| sclk_pin | input | 1 | Serial clock from the master, idles low |
| csn_pin | input | 1 | Chip select, active low |
| tx_byte | input | DATA_W | Parallel word captured when chip select falls |
| miso | output | 1 | Serial data to the master, MSB first |
| frame_done | output | 1 | One-cycle pulse after the last bit has been read |

## Verification
The main function is tried with all-zero, all-one, alternating and single-bit bytes, and then with random bytes. Alternating patterns show whether the data shifts one place per serial edge or gets double-stepped. Single-bit bytes show the bit order and any shift offset. Random bytes are mixed with changes on `tx_byte` during the frame, to show whether the data is captured once or sampled live. Short pulses of one or two system clocks are injected into both phases of the serial clock. These pulses separate a filtered design from one that would count the glitch as an edge, and the same stimulus drives a second instance that uses the prescaler. Frames are also aborted after a few bits, which shows whether the abort leaks a completion pulse or leaves stale bit-position state behind.

// File: rtl/ovs_spi_pkg.sv
package ovs_spi_pkg;

   typedef struct packed {
      logic rise;
      logic fall;
   } edge_t;

endpackage

// File: rtl/ovs_rst_sync.sv
module ovs_rst_sync (
   input  logic clk,
   input  logic rst_ext,
   output logic rst
);
   logic [1:0] stage_q;

   always_ff @(posedge clk) begin
      stage_q <= {stage_q[0], rst_ext};
   end

   assign rst = stage_q[1];
endmodule

// File: rtl/ovs_sync.sv
module ovs_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("ovs_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (rst) chain_q <= {STAGES{RST_VAL}};
      else     chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/ovs_prescale.sv
module ovs_prescale #(
   parameter int PRESCALE = 1
) (
   input  logic clk,
   input  logic rst,
   output logic en
);
   if (PRESCALE < 1) begin : g_bad_div
      $error("ovs_prescale: PRESCALE must be at least 1");
   end

   if (PRESCALE == 1) begin : g_full_rate
      assign en = 1'b1;
   end else begin : g_divided
      localparam int DW = $clog2(PRESCALE);
      logic [DW-1:0] div_q;

      always_ff @(posedge clk) begin
         if (rst)                           div_q <= '0;
         else if (div_q == DW'(PRESCALE-1)) div_q <= '0;
         else                               div_q <= div_q + DW'(1);
      end

      assign en = (div_q == '0);
   end
endmodule

// File: rtl/ovs_glitch_filt.sv
module ovs_glitch_filt #(
   parameter int   LEN     = 3,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic en,
   input  logic d,
   output logic q
);
   logic lvl_q;

   if (LEN < 1) begin : g_bad_len
      $error("ovs_glitch_filt: LEN must be at least 1");
   end

   if (LEN == 1) begin : g_pass
      always_ff @(posedge clk) begin
         if (rst)     lvl_q <= RST_VAL;
         else if (en) lvl_q <= d;
      end
   end else begin : g_filter
      localparam int CW = $clog2(LEN);
      logic [CW-1:0] run_q;

      always_ff @(posedge clk) begin
         if (rst) begin
            lvl_q <= RST_VAL;
            run_q <= '0;
         end else if (en) begin
            if (d == lvl_q) begin
               run_q <= '0;
            end else if (run_q == CW'(LEN-1)) begin
               lvl_q <= d;
               run_q <= '0;
            end else begin
               run_q <= run_q + CW'(1);
            end
         end
      end
   end

   assign q = lvl_q;
endmodule

// File: rtl/ovs_edge_det.sv
module ovs_edge_det
   import ovs_spi_pkg::*;
(
   input  logic  clk,
   input  logic  rst,
   input  logic  en,
   input  logic  lvl,
   output edge_t ev
);
   logic prev_q;

   always_ff @(posedge clk) begin
      if (rst)     prev_q <= 1'b0;
      else if (en) prev_q <= lvl;
   end

   // history pair {prev, now}: 01 rising, 10 falling
   assign ev.rise = en & ({prev_q, lvl} == 2'b01);
   assign ev.fall = en & ({prev_q, lvl} == 2'b10);
endmodule

// File: rtl/ovs_spi_tx.sv
module ovs_spi_tx
   import ovs_spi_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3,
   parameter int PRESCALE    = 1
) (
   input  logic              clk,
   input  logic              rst_ext,
   input  logic              sclk_pin,
   input  logic              csn_pin,
   input  logic [DATA_W-1:0] tx_byte,
   output logic              miso,
   output logic              frame_done
);
   localparam int                CW   = $clog2(DATA_W);
   localparam logic [CW-1:0]     LAST = CW'(DATA_W-1);

   if (DATA_W < 2) begin : g_bad_width
      $error("ovs_spi_tx: DATA_W must be at least 2");
   end

   logic          rst_q;
   logic          sclk_s, csn_s, sclk_f, smp_en, cs_act, cs_q, fin_q;
   edge_t         sev;
   logic [CW-1:0] bit_cnt;
   logic [DATA_W-1:0] shreg;

   ovs_rst_sync u_rst (.clk(clk), .rst_ext(rst_ext), .rst(rst_q));

   ovs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
      .clk(clk), .rst(rst_q), .d(sclk_pin), .q(sclk_s));

   ovs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_csn (
      .clk(clk), .rst(rst_q), .d(csn_pin), .q(csn_s));

   ovs_prescale #(.PRESCALE(PRESCALE)) u_div (
      .clk(clk), .rst(rst_q), .en(smp_en));

   ovs_glitch_filt #(.LEN(FILT_LEN), .RST_VAL(1'b0)) u_filt (
      .clk(clk), .rst(rst_q), .en(smp_en), .d(sclk_s), .q(sclk_f));

   ovs_edge_det u_edge (
      .clk(clk), .rst(rst_q), .en(smp_en), .lvl(sclk_f), .ev(sev));

   assign cs_act = ~csn_s;

   always_ff @(posedge clk) begin
      if (rst_q) begin
         cs_q       <= 1'b0;
         bit_cnt    <= LAST;
         shreg      <= '1;
         fin_q      <= 1'b0;
         frame_done <= 1'b0;
      end else begin
         cs_q       <= cs_act;
         frame_done <= 1'b0;
         if (!cs_act) begin
            bit_cnt <= LAST;
            shreg   <= '1;
            fin_q   <= 1'b0;
         end else if (!cs_q) begin
            bit_cnt <= LAST;
            shreg   <= tx_byte;
            fin_q   <= 1'b0;
         end else begin
            if (sev.fall) shreg <= {shreg[DATA_W-2:0], 1'b1};
            if (sev.rise && !fin_q) begin
               if (bit_cnt != '0) begin
                  bit_cnt <= bit_cnt - CW'(1);
               end else begin
                  fin_q      <= 1'b1;
                  frame_done <= 1'b1;
               end
            end
         end
      end
   end

   assign miso = shreg[DATA_W-1];
endmodule

// File: rtl/ovs_spi_tx_chk.sv
module ovs_spi_tx_chk #(
   parameter int W  = 8,
   parameter int CW = 3
) (
   input logic          clk,
   input logic          rst,
   input logic          csn_pin,
   input logic          miso,
   input logic          frame_done,
   input logic          cs_act,
   input logic [CW-1:0] bit_cnt,
   input logic          sclk_s,
   input logic          sclk_f
);
   a_r2_idle_high: assert property (@(posedge clk) disable iff (rst)
      (csn_pin && $past(csn_pin) && $past(csn_pin, 2) && $past(csn_pin, 3)) |-> miso);

   a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
      frame_done |=> !frame_done);

   a_r6_done_in_frame: assert property (@(posedge clk) disable iff (rst)
      frame_done |-> $past(cs_act));

   a_r7_no_done_idle: assert property (@(posedge clk) disable iff (rst)
      !cs_act |=> !frame_done);

   a_r4_count_step: assert property (@(posedge clk) disable iff (rst)
      !$stable(bit_cnt) |->
         ((bit_cnt == CW'($past(bit_cnt) - CW'(1))) || (bit_cnt == CW'(W-1))));

   a_r8_filter_follows: assert property (@(posedge clk) disable iff (rst)
      !$stable(sclk_f) |-> (sclk_f == $past(sclk_s)));
endmodule

bind ovs_spi_tx ovs_spi_tx_chk #(.W(DATA_W), .CW(CW)) u_chk (
   .clk(clk), .rst(rst_q), .csn_pin(csn_pin), .miso(miso),
   .frame_done(frame_done), .cs_act(cs_act), .bit_cnt(bit_cnt),
   .sclk_s(sclk_s), .sclk_f(sclk_f));

// File: tb/sim_ovs_spi_tx.sv
module sim_ovs_spi_tx;
   localparam int PH = 32;

   logic       clk = 1'b0;
   logic       rst_ext = 1'b1;
   logic       sclk = 1'b0;
   logic       csn = 1'b1;
   logic [7:0] tx_byte = 8'h00;
   logic       miso0, miso1, fd0, fd1;
   int         checks = 0;
   int         errors = 0;
   int         dn0 = 0;
   int         dn1 = 0;
   bit         done_flag = 1'b0;

   always #2.5 clk = ~clk;

   ovs_spi_tx u0 (.clk(clk), .rst_ext(rst_ext), .sclk_pin(sclk), .csn_pin(csn),
                  .tx_byte(tx_byte), .miso(miso0), .frame_done(fd0));

   ovs_spi_tx #(.PRESCALE(4), .FILT_LEN(2)) u1 (
      .clk(clk), .rst_ext(rst_ext), .sclk_pin(sclk), .csn_pin(csn),
      .tx_byte(tx_byte), .miso(miso1), .frame_done(fd1));

   always @(posedge clk) begin
      if (fd0 === 1'b1) dn0 <= dn0 + 1;
      if (fd1 === 1'b1) dn1 <= dn1 + 1;
   end

   function automatic logic exp_bit(input logic [7:0] b, input int i);
      return b[7-i];
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   // one serial half period; an optional short pulse of the opposite level
   task automatic half(input logic lvl, input bit glitch);
      int w;
      sclk = lvl;
      if (glitch) begin
         w = 1 + int'($urandom % 2);
         wait_clk(12);
         sclk = ~lvl;
         wait_clk(w);
         sclk = lvl;
         wait_clk(PH - 12 - w);
      end else begin
         wait_clk(PH);
      end
   endtask

   task automatic run_frame(input logic [7:0] b, input int nbits, input bit glitch);
      int d0, d1;
      d0 = dn0;
      d1 = dn1;
      tx_byte = b;
      csn = 1'b0;
      wait_clk(PH);
      tx_byte = 8'($urandom);  // R5: must not disturb the frame
      for (int i = 0; i < nbits; i++) begin
         check((i == 0) ? "R3 first bit u0" : "R4/R5/R8 bit u0", int'(miso0), int'(exp_bit(b, i)));
         check("R9 bit u1", int'(miso1), int'(exp_bit(b, i)));
         half(1'b1, glitch);
         half(1'b0, glitch);
      end
      if (nbits == 8) begin
         check("R6 miso after last bit u0", int'(miso0), 1);
         check("R6 one done pulse u0", dn0, d0 + 1);
         check("R9 one done pulse u1", dn1, d1 + 1);
      end
      csn = 1'b1;
      wait_clk(PH);
      if (nbits < 8) begin
         check("R7 no done on abort u0", dn0, d0);
         check("R7 no done on abort u1", dn1, d1);
      end
      check("R2 idle high u0", int'(miso0), 1);
   endtask

   initial begin
      void'($urandom(32'h5eed_0001));
      wait_clk(10);
      rst_ext = 1'b0;
      wait_clk(4);
      check("R1 reset miso", int'(miso0), 1);
      check("R1 reset frame_done", int'(fd0), 0);

      // R2: serial clock toggles while deselected
      for (int i = 0; i < 4; i++) begin
         half(1'b1, 1'b0);
         half(1'b0, 1'b0);
         check("R2 miso while deselected", int'(miso0), 1);
      end
      check("R2 no done while deselected", dn0, 0);

      run_frame(8'h00, 8, 1'b0);
      run_frame(8'hFF, 8, 1'b0);
      run_frame(8'hA5, 8, 1'b0);
      run_frame(8'h5A, 8, 1'b1);
      run_frame(8'h80, 8, 1'b0);
      run_frame(8'h01, 8, 1'b1);
      // R7: abort mid frame, then a full frame from the MSB
      run_frame(8'hC3, 3, 1'b0);
      run_frame(8'h3C, 8, 1'b0);
      run_frame(8'h96, 5, 1'b1);
      run_frame(8'h69, 8, 1'b1);
      for (int k = 0; k < 12; k++) begin
         run_frame(8'($urandom), 8, bit'($urandom % 2));
      end

      if (!done_flag) begin
         done_flag = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done_flag) begin
         done_flag = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual 0 expected 1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule